// File: doc/BRIEF.md
# Triggered Binary Hit Latency Pipeline

This block sits behind a bank of per-channel discriminators. On every bunch-crossing clock it takes one binary word (one bit per channel, no sparsification) and stores it in a circular history memory. A level-1 trigger selects the word that was stored a programmable number of crossings earlier. That word is copied into a small event queue together with the memory slot it came from. It waits there until downstream readout pops it.

Two faults are tracked as sticky flags, and their state is stamped into every queued event. The first is a latency fault: the latency setting is zero, or the captured slot does not match an independently kept reference pointer. The second is a queue overflow: a trigger arrived while the queue was full, so its event was discarded. Only reset clears either flag.

Top module: `binary_trig_pipe`

## Requirements
- R1: After synchronous reset, `evt_valid_o`, `err_lat_o` and `err_ovf_o` are 0, and the write pointer restarts at slot 0. The first crossing after reset is stored in slot 0, the next one in slot 1, and so on.
- R2: A trigger sampled at the clock edge that stores crossing number n (counted from 0 after reset), with latency L ≥ 1, yields an event with `evt_addr_o` = (n − L) mod 256 and `evt_hits_o` equal to the word stored at crossing n − L.
- R3: If fewer than L crossings have been stored since reset, the triggered event carries an all-zero hit word, but still carries its slot address.
- R4: The event of a trigger sampled at edge E0 becomes visible at the queue head after edge E0+1.
- R5: The queue holds up to 32 events and delivers them oldest first. A high `pop_i` while `evt_valid_o` is 1 removes the head at the next edge.
- R6: An event produced while the queue holds 32 entries is discarded and `err_ovf_o` goes to 1. Each queued event carries in `evt_ovf_o` the overflow flag's value at the time it was queued.
- R7: A trigger with latency 0, or with a captured slot that differs from the reference pointer minus latency, sets `err_lat_o`. The event of that trigger carries `evt_lat_err_o` = 1.
- R8: Triggers on consecutive clock edges each produce their own event, with no loss.
- R9: `err_lat_o` and `err_ovf_o` stay at 1 once set, until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Level-1 trigger for the current crossing |
| lat_i | input | 8 | Latency in crossings |
| hit_i | input | 128 | Binary hit word, one bit per channel |
| pop_i | input | 1 | Remove the queue head |
| evt_valid_o | output | 1 | Queue head holds an event |
| evt_addr_o | output | 8 | Memory slot of the head event |
| evt_hits_o | output | 128 | Hit word of the head event |
| evt_lat_err_o | output | 1 | Latency fault state stamped on the head event |
| evt_ovf_o | output | 1 | Overflow state stamped on the head event |
| err_lat_o | output | 1 | Sticky latency fault |
| err_ovf_o | output | 1 | Sticky queue overflow |

## Verification
Each stored crossing gets a distinct word computed from its crossing number. A wrong slot, an off-by-one latency or stale data after the pointer wraps therefore shows up as a wrong word, not as a silent match.

Latencies of 1, 255 and a half-ring value are tested, at isolated and back-to-back trigger spacings. This separates address arithmetic errors from pipeline-timing errors. Early triggers with latencies larger than the fill depth separate the unfilled-slot masking from the plain read path.

A burst of 34 triggers tells a correct drop-on-full apart from an overwrite. A zero-latency trigger exercises the latency fault and its stamp on the event.

// File: rtl/hit_pipe_pkg.sv
package hit_pipe_pkg;
  // fault stamp carried with each queued event
  typedef struct packed {
    logic lat_err;
    logic ovf;
  } evt_flags_t;

  // slot that held the crossing lat cycles before the slot at ptr
  function automatic logic [15:0] ring_back(input logic [15:0] ptr,
                                            input logic [15:0] lat,
                                            input int unsigned aw);
    logic [15:0] diff;
    diff = ptr - lat;
    return diff & ((16'd1 << aw) - 16'd1);
  endfunction
endpackage

// File: rtl/lat_ring.sv
module lat_ring #(
  parameter int NCH   = 128,
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           trig_i,
  input  logic [AW-1:0]  lat_i,
  input  logic [NCH-1:0] hit_i,
  output logic           rd_vld_o,
  output logic [AW-1:0]  rd_addr_o,
  output logic [NCH-1:0] rd_hits_o,
  output logic           lat_bad_o
);
  import hit_pipe_pkg::*;

  logic [NCH-1:0] mem [DEPTH];
  logic [NCH-1:0] rdata_q;
  logic [AW-1:0]  wptr, ref_ptr, raddr, ref_addr;
  logic           wrapped, fill_ok, fill_ok_q, bad;

  assign raddr    = wptr - lat_i;
  assign ref_addr = AW'(ring_back(16'(ref_ptr), 16'(lat_i), AW));
  assign fill_ok  = wrapped || (raddr < wptr);
  assign bad      = (raddr != ref_addr) || (lat_i == '0);

  // block-RAM style port: write every crossing, registered read
  always_ff @(posedge clk) begin
    mem[wptr] <= hit_i;
    rdata_q   <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr      <= '0;
      ref_ptr   <= '0;
      wrapped   <= 1'b0;
      rd_vld_o  <= 1'b0;
      rd_addr_o <= '0;
      fill_ok_q <= 1'b0;
      lat_bad_o <= 1'b0;
    end else begin
      wptr      <= wptr + 1'b1;
      ref_ptr   <= ref_ptr + 1'b1;
      if (wptr == AW'(DEPTH - 1)) wrapped <= 1'b1;
      rd_vld_o  <= trig_i;
      rd_addr_o <= raddr;
      fill_ok_q <= fill_ok;
      lat_bad_o <= trig_i && bad;
    end
  end

  assign rd_hits_o = fill_ok_q ? rdata_q : '0;

  // R1
  wptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> wptr == AW'($past(wptr) + 1'b1));
  // R3
  wrapped_hold_chk: assert property (@(posedge clk) disable iff (rst)
    wrapped |=> wrapped);
  // R2
  rd_addr_chk: assert property (@(posedge clk) disable iff (rst)
    trig_i |=> rd_addr_o == AW'($past(wptr) - $past(lat_i)));
endmodule

// File: rtl/trig_fifo.sv
module trig_fifo #(
  parameter int W     = 138,
  parameter int DEPTH = 32,
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic         valid_o,
  output logic [W-1:0] data_o,
  output logic         drop_o
);
  localparam logic [PW:0] FULL = (PW+1)'(DEPTH);

  logic [W-1:0] store [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [PW:0]   cnt;
  logic          do_push, do_pop;

  assign do_push = push_i && (cnt != FULL);
  assign do_pop  = pop_i && (cnt != '0);
  assign drop_o  = push_i && (cnt == FULL);
  assign valid_o = (cnt != '0);
  assign data_o  = store[rp];

  always_ff @(posedge clk) begin
    if (do_push) store[wp] <= data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL);
  // R5
  head_hold_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o && !pop_i |=> valid_o);
  // R6
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    drop_o && !pop_i |=> cnt == FULL);
endmodule

// File: rtl/binary_trig_pipe.sv
module binary_trig_pipe #(
  parameter int NCH        = 128,
  parameter int PIPE_DEPTH = 256,
  parameter int EVT_DEPTH  = 32,
  parameter int AW         = $clog2(PIPE_DEPTH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           trig_i,
  input  logic [AW-1:0]  lat_i,
  input  logic [NCH-1:0] hit_i,
  input  logic           pop_i,
  output logic           evt_valid_o,
  output logic [AW-1:0]  evt_addr_o,
  output logic [NCH-1:0] evt_hits_o,
  output logic           evt_lat_err_o,
  output logic           evt_ovf_o,
  output logic           err_lat_o,
  output logic           err_ovf_o
);
  import hit_pipe_pkg::*;

  localparam int EW = $bits(evt_flags_t) + AW + NCH;

  logic           rd_vld, lat_bad, drop;
  logic [AW-1:0]  rd_addr;
  logic [NCH-1:0] rd_hits;
  evt_flags_t     in_flags, out_flags;
  logic [EW-1:0]  evt_in, evt_out;

  lat_ring #(.NCH(NCH), .DEPTH(PIPE_DEPTH), .AW(AW)) u_ring (
    .clk(clk), .rst(rst), .trig_i(trig_i), .lat_i(lat_i), .hit_i(hit_i),
    .rd_vld_o(rd_vld), .rd_addr_o(rd_addr), .rd_hits_o(rd_hits),
    .lat_bad_o(lat_bad)
  );

  assign in_flags.lat_err = err_lat_o | lat_bad;
  assign in_flags.ovf     = err_ovf_o;
  assign evt_in           = {in_flags, rd_addr, rd_hits};

  trig_fifo #(.W(EW), .DEPTH(EVT_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push_i(rd_vld), .data_i(evt_in),
    .pop_i(pop_i), .valid_o(evt_valid_o), .data_o(evt_out), .drop_o(drop)
  );

  assign {out_flags, evt_addr_o, evt_hits_o} = evt_out;
  assign evt_lat_err_o = out_flags.lat_err;
  assign evt_ovf_o     = out_flags.ovf;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_lat_o <= 1'b0;
      err_ovf_o <= 1'b0;
    end else begin
      if (rd_vld && lat_bad) err_lat_o <= 1'b1;
      if (drop)              err_ovf_o <= 1'b1;
    end
  end

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_ovf_o |=> err_ovf_o);
  // R9
  lat_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_lat_o |=> err_lat_o);
  // R7
  zero_lat_chk: assert property (@(posedge clk) disable iff (rst)
    trig_i && lat_i == '0 |-> ##2 err_lat_o);
  // R4
  evt_appear_chk: assert property (@(posedge clk) disable iff (rst)
    trig_i && !pop_i |-> ##2 evt_valid_o);
endmodule

// File: tb/tb_binary_trig_pipe.sv
module tb_binary_trig_pipe;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         trig_i = 1'b0;
  logic [7:0]   lat_i = '0;
  logic [127:0] hit_i;
  logic         pop_i = 1'b0;
  logic         evt_valid_o, evt_lat_err_o, evt_ovf_o, err_lat_o, err_ovf_o;
  logic [7:0]   evt_addr_o;
  logic [127:0] evt_hits_o;

  int total = 0, bad = 0, wc = 0, head = 0, tail = 0;
  logic [7:0]   e_addr [64];
  logic [127:0] e_hits [64];
  logic         e_le   [64];
  logic         e_ov   [64];

  typedef struct packed { logic [7:0] lat; logic [7:0] gap; } vec_t;
  localparam vec_t VT [8] = '{
    '{8'd1, 8'd3}, '{8'd7, 8'd0}, '{8'd255, 8'd5}, '{8'd128, 8'd0},
    '{8'd2, 8'd0}, '{8'd64, 8'd9}, '{8'd200, 8'd1}, '{8'd33, 8'd0}};

  always #4 clk = ~clk;

  binary_trig_pipe dut (
    .clk(clk), .rst(rst), .trig_i(trig_i), .lat_i(lat_i), .hit_i(hit_i),
    .pop_i(pop_i), .evt_valid_o(evt_valid_o), .evt_addr_o(evt_addr_o),
    .evt_hits_o(evt_hits_o), .evt_lat_err_o(evt_lat_err_o),
    .evt_ovf_o(evt_ovf_o), .err_lat_o(err_lat_o), .err_ovf_o(err_ovf_o));

  function automatic logic [127:0] pat(input int n);
    logic [31:0] x;
    x = 32'(n) * 32'h9E3779B1 + 32'h01234567;
    return {x, ~x, x ^ 32'h55AA55AA, 16'(n), 16'hBEEF};
  endfunction

  assign hit_i = pat(wc);
  always @(posedge clk) wc <= rst ? 0 : wc + 1;

  task automatic chk(input string req, input logic [127:0] act, exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // called at a negedge: trigger for the crossing stored at the next edge
  task automatic fire(input logic [7:0] lat, input bit keep);
    trig_i = 1'b1;
    lat_i  = lat;
    if (keep) begin
      e_addr[tail] = 8'(wc - int'(lat));
      e_hits[tail] = (lat != 0 && wc >= int'(lat)) ? pat(wc - int'(lat)) : '0;
      e_le[tail]   = (lat == 0);
      e_ov[tail]   = 1'b0;
      tail++;
    end
    @(negedge clk);
  endtask

  task automatic stop_fire;
    trig_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic drain;
    while (head < tail) begin
      chk("R5 valid", 128'(evt_valid_o), 128'd1);
      chk("R2 addr", 128'(evt_addr_o), 128'(e_addr[head]));
      chk("R2 hits", evt_hits_o, e_hits[head]);
      chk("R7 lat flag", 128'(evt_lat_err_o), 128'(e_le[head]));
      chk("R6 ovf flag", 128'(evt_ovf_o), 128'(e_ov[head]));
      pop_i = 1'b1;
      head++;
      @(negedge clk);
      pop_i = 1'b0;
    end
    chk("R5 empty", 128'(evt_valid_o), 128'd0);
  endtask

  task automatic do_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    head = 0;
    tail = 0;
  endtask

  task automatic summary;
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(8 * 20000);
    bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 valid", 128'(evt_valid_o), 128'd0);
    chk("R1 err_lat", 128'(err_lat_o), 128'd0);
    chk("R1 err_ovf", 128'(err_ovf_o), 128'd0);
    repeat (3) @(negedge clk);
    // R3 unfilled slot, then R1/R2 slot 0 reached from an early trigger
    fire(8'd10, 1'b1);
    fire(8'(wc), 1'b1);
    trig_i = 1'b0;
    // R4 event visible after the edge that follows the trigger edge
    chk("R4 visible", 128'(evt_valid_o), 128'd1);
    @(negedge clk);
    drain();
    repeat (300) @(negedge clk);
    // table: R2 latencies, R8 back-to-back spacing
    foreach (VT[i]) begin
      trig_i = 1'b0;
      repeat (int'(VT[i].gap)) @(negedge clk);
      fire(VT[i].lat, 1'b1);
    end
    stop_fire();
    drain();
    // R6 overflow: 34 back-to-back triggers, 32 kept
    do_reset();
    chk("R9 ovf cleared", 128'(err_ovf_o), 128'd0);
    repeat (4) @(negedge clk);
    for (int k = 0; k < 34; k++) fire(8'd1, k < 32);
    stop_fire();
    @(negedge clk);
    chk("R6 err_ovf set", 128'(err_ovf_o), 128'd1);
    drain();
    chk("R9 ovf still set", 128'(err_ovf_o), 128'd1);
    // R7 zero latency
    do_reset();
    chk("R9 lat cleared", 128'(err_lat_o), 128'd0);
    repeat (5) @(negedge clk);
    fire(8'd0, 1'b1);
    stop_fire();
    chk("R7 err_lat set", 128'(err_lat_o), 128'd1);
    drain();
    repeat (4) @(negedge clk);
    chk("R9 lat still set", 128'(err_lat_o), 128'd1);
    summary();
    $finish;
  end
endmodule